// File: doc/BRIEF.md
# Battery-Backed RAM Bank Select Controller

This block produces the active-low chip selects for a bank of static RAMs that stay powered from a battery while the main supply is away. A binary bank address picks one RAM. A master active-low enable frames each memory access. While the supply is good, the enable and the address decode to a single active select. An external comparator raises a supply-fail flag when the supply drifts out of tolerance. The block then lowers its power-fail output and blocks every select. An access that is already under way when the flag appears is allowed to finish first.

When the supply returns, the selects stay blocked for a fixed recovery interval, counted in clock cycles. The power-fail output stays low until that interval ends. Two battery-low flags, one from each of two batteries, are sampled as each recovery interval closes. If both report low, the second memory access after power-up is suppressed. Software detects this by writing a location and then failing to read the value back. All flag inputs pass through clock synchronisers before use.

Top module: `nvram_bank_guard`

## Requirements
- R1: While `mem_en_n` is high, every bit of `ram_sel_n` is high. At no time is more than one bit of `ram_sel_n` low.
- R2: With power good and `mem_en_n` low, bit `ram_sel_n[i]` is the only low bit, where i is the unsigned value of `bank_addr`. Bit 3 of the address is the most significant bit.
- R3: While `mem_en_n` stays low with power good, a new `bank_addr` moves the low select to the newly addressed bit in the same cycle.
- R4: Within four clock cycles after `supply_fail` rises, `pwr_fail_n` is low. From then on, any new access leaves every `ram_sel_n` bit high.
- R5: If `mem_en_n` is low when the supply fault takes effect, `ram_sel_n` keeps its value even when `bank_addr` changes. It goes all high once `mem_en_n` goes high.
- R6: After `supply_fail` falls, `pwr_fail_n` stays low and the selects stay blocked for SYNC_STAGES + 1 + REC_CYCLES - 1 clock cycles. `pwr_fail_n` rises in the cycle after that.
- R7: While `rst_n` is low, `pwr_fail_n` is low and `ram_sel_n` is all high. Leaving reset starts a recovery interval of REC_CYCLES cycles.
- R8: If both battery-low flags are high when recovery ends, the second completed-enable access after power-up leaves `ram_sel_n` all high.
- R9: Under the battery warning, the first access and the third and later accesses decode normally. The inhibit applies once per power-up.
- R10: If only one of the two battery-low flags is high, no access is inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_addr | input | 4 | Binary RAM index, bit 3 most significant |
| mem_en_n | input | 1 | Master access enable, active low |
| supply_fail | input | 1 | Supply out of tolerance, active high, asynchronous |
| batt_low_a | input | 1 | First battery below threshold, active high, asynchronous |
| batt_low_b | input | 1 | Second battery below threshold, active high, asynchronous |
| ram_sel_n | output | 16 | Per-RAM chip selects, active low |
| pwr_fail_n | output | 1 | Power-fail indication, active low |

## Verification
The bench builds the block with REC_CYCLES = 20, two synchroniser stages and sixteen banks. The short recovery interval lets every scenario pass through several full power-up sequences. It also lets the bench confirm the exact cycle where `pwr_fail_n` rises after reset and after a supply return. Directed scenarios cover the full address sweep, an access held across a supply fault, and the three battery-flag combinations, each followed by enough accesses to pass the inhibited second one.

// File: rtl/nvbg_pkg.sv
// Package: shared state encoding for the bank guard.
// Assumes: only the power sequencer writes the state; other modules only read it.
package nvbg_pkg;
    typedef enum logic [1:0] {
        PS_RECOVER = 2'd0,
        PS_ACTIVE  = 2'd1,
        PS_HOLD    = 2'd2,
        PS_PROTECT = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/nvbg_sync.sv
// Module: multi-stage flip-flop synchroniser for a bundle of slow flags.
// Assumes: each bit is independent and quasi-static; reset clears every stage.
module nvbg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            // Purpose: resolve metastability in the following stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/nvbg_power_fsm.sv
// Module: power sequencer. Tracks recovery, normal operation, a held access and protection.
// Assumes: fail_s is already synchronised; reset starts a recovery interval.
module nvbg_power_fsm
    import nvbg_pkg::*;
#(
    parameter int REC_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fail_s,
    input  logic       mem_en_n,
    output pwr_state_t state,
    output logic       recov_done,
    output logic       pwr_fail_n
);
    localparam int REC_W = (REC_CYCLES > 2) ? $clog2(REC_CYCLES) : 1;
    localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_CYCLES - 1);

    pwr_state_t       state_d;
    logic [REC_W-1:0] rec_cnt, rec_cnt_d;

    // Purpose: choose the next power state and the recovery count.
    always_comb begin
        state_d    = state;
        rec_cnt_d  = rec_cnt;
        recov_done = 1'b0;
        case (state)
            PS_RECOVER: begin
                if (fail_s) begin
                    state_d = PS_PROTECT;
                end else if (rec_cnt == REC_LAST) begin
                    state_d    = PS_ACTIVE;
                    recov_done = 1'b1;
                end else begin
                    rec_cnt_d = rec_cnt + 1'b1;
                end
            end
            PS_ACTIVE:  if (fail_s) state_d = mem_en_n ? PS_PROTECT : PS_HOLD;
            PS_HOLD:    if (mem_en_n) state_d = PS_PROTECT;
            PS_PROTECT: if (!fail_s) begin
                state_d   = PS_RECOVER;
                rec_cnt_d = '0;
            end
            default:    state_d = PS_PROTECT;
        endcase
    end

    // Purpose: hold state and count; reset enters recovery from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_RECOVER;
            rec_cnt <= '0;
        end else begin
            state   <= state_d;
            rec_cnt <= rec_cnt_d;
        end
    end

    assign pwr_fail_n = (state == PS_ACTIVE);

    // R6: power-fail lifts only right after the recovery count reached its end.
    a_r6_recovery_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_fail_n) |-> ($past(rec_cnt) == REC_LAST));
    // R7: the first cycle after reset is still protected.
    a_r7_reset_protected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pwr_fail_n);
    // R4: a synchronised fault always takes the sequencer out of normal operation.
    a_r4_fault_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && fail_s) |=> (state != PS_ACTIVE));
endmodule

// File: rtl/nvbg_batt_guard.sv
// Module: battery warning latch and completed-access counter. Flags the second access.
// Assumes: both_low_s is synchronised; recov_done pulses once as recovery ends.
module nvbg_batt_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic both_low_s,
    input  logic recovering,
    input  logic recov_done,
    input  logic active,
    input  logic mem_en_n,
    output logic inhibit
);
    logic       warn;
    logic       prev_en_n;
    logic       cyc_open;
    logic [1:0] cyc_cnt;

    // Purpose: latch the warning at power-up and count completed accesses, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn      <= 1'b0;
            prev_en_n <= 1'b1;
            cyc_open  <= 1'b0;
            cyc_cnt   <= 2'd0;
        end else begin
            prev_en_n <= mem_en_n;
            if (recovering) begin
                cyc_open <= 1'b0;
                cyc_cnt  <= 2'd0;
                if (recov_done) warn <= both_low_s;
            end else if (active) begin
                if (prev_en_n && !mem_en_n) begin
                    cyc_open <= 1'b1;
                end else if (!prev_en_n && mem_en_n && cyc_open) begin
                    cyc_open <= 1'b0;
                    if (cyc_cnt != 2'd2) cyc_cnt <= cyc_cnt + 2'd1;
                end
            end
        end
    end

    assign inhibit = warn && (cyc_cnt == 2'd1);

    // R9: the access counter never passes its saturation value.
    a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_cnt <= 2'd2);
    // R8: the warning changes only while a recovery interval is running.
    a_r8_warn_sampled_at_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        !recovering |=> $stable(warn));
endmodule

// File: rtl/nvbg_decoder.sv
// Module: binary to one-hot decoder, active high.
// Assumes: NUM fits in the address width.
module nvbg_decoder #(
    parameter int NUM    = 16,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM-1:0]    onehot
);
    for (genvar g = 0; g < NUM; g++) begin : g_dec
        assign onehot[g] = (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/nvram_bank_guard.sv
// Module: top of the bank guard. Decodes the RAM selects and gates them by the power state,
// holding an in-flight access across a supply fault.
// Assumes: bank_addr and mem_en_n are synchronous to clk; the fault and battery flags are not.
module nvram_bank_guard
    import nvbg_pkg::*;
#(
    parameter int NUM_BANKS   = 16,
    parameter int REC_CYCLES  = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_addr,
    input  logic                         mem_en_n,
    input  logic                         supply_fail,
    input  logic                         batt_low_a,
    input  logic                         batt_low_b,
    output logic [NUM_BANKS-1:0]         ram_sel_n,
    output logic                         pwr_fail_n
);
    localparam int ADDR_W = $clog2(NUM_BANKS);

    logic [2:0]           flags_s;
    pwr_state_t           state;
    logic                 recov_done;
    logic                 inhibit;
    logic [NUM_BANKS-1:0] onehot;
    logic [NUM_BANKS-1:0] live_sel;
    logic [NUM_BANKS-1:0] held_sel;

    nvbg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({batt_low_b, batt_low_a, supply_fail}),
        .dout (flags_s)
    );

    nvbg_power_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_s    (flags_s[0]),
        .mem_en_n  (mem_en_n),
        .state     (state),
        .recov_done(recov_done),
        .pwr_fail_n(pwr_fail_n)
    );

    nvbg_batt_guard u_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .both_low_s(flags_s[1] & flags_s[2]),
        .recovering(state == PS_RECOVER),
        .recov_done(recov_done),
        .active    (state == PS_ACTIVE),
        .mem_en_n  (mem_en_n),
        .inhibit   (inhibit)
    );

    nvbg_decoder #(.NUM(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr  (bank_addr),
        .onehot(onehot)
    );

    assign live_sel = ~(onehot & {NUM_BANKS{!mem_en_n && !inhibit}});

    // Purpose: track the live selects while active so a held access keeps them.
    always_ff @(posedge clk) begin
        if (!rst_n)                 held_sel <= '1;
        else if (state == PS_ACTIVE) held_sel <= live_sel;
    end

    // Purpose: pick the select source by power state.
    always_comb begin
        case (state)
            PS_ACTIVE: ram_sel_n = live_sel;
            PS_HOLD:   ram_sel_n = held_sel | {NUM_BANKS{mem_en_n}};
            default:   ram_sel_n = '1;
        endcase
    end

    // R1: never more than one select active.
    a_r1_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ram_sel_n) <= 1);
    // R4: with power failed and no access open, all selects are inactive.
    a_r4_blocked_when_failed: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail_n && mem_en_n) |-> (&ram_sel_n));
    // R5: a held access keeps its selects steady while the enable stays low.
    a_r5_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_HOLD && $past(state == PS_HOLD) && !mem_en_n) |-> $stable(ram_sel_n));
endmodule

// File: tb/nvram_bank_guard_bench.sv
module nvram_bank_guard_bench;
    localparam int NB  = 16;
    localparam int REC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bank_addr = '0;
    logic          mem_en_n = 1'b1;
    logic          supply_fail = 1'b0;
    logic          batt_low_a = 1'b0;
    logic          batt_low_b = 1'b0;
    logic [NB-1:0] ram_sel_n;
    logic          pwr_fail_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nvram_bank_guard #(.NUM_BANKS(NB), .REC_CYCLES(REC), .SYNC_STAGES(2)) u_nvram_bank_guard (
        .clk(clk), .rst_n(rst_n), .bank_addr(bank_addr), .mem_en_n(mem_en_n),
        .supply_fail(supply_fail), .batt_low_a(batt_low_a), .batt_low_b(batt_low_b),
        .ram_sel_n(ram_sel_n), .pwr_fail_n(pwr_fail_n)
    );

    function automatic logic [NB-1:0] sel_of(input int a);
        return ~(NB'(1) << a);
    endfunction

    task automatic chk16(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ram_sel_n got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pwr_fail_n got %b expected %b", req, act, exp);
        end
    endtask

    // One access: enable low for one cycle, then high.
    task automatic access(input int a, input bit inh, input string req);
        @(negedge clk);
        bank_addr = 4'(a);
        mem_en_n  = 1'b0;
        #1 chk16(req, ram_sel_n, inh ? '1 : sel_of(a));
        @(negedge clk);
        mem_en_n = 1'b1;
        #1 chk16("R1 idle after access", ram_sel_n, '1);
    endtask

    // Reset with the given battery flags, then check the exact end of recovery (R7, R6).
    task automatic power_up(input logic ba, input logic bb);
        @(negedge clk);
        rst_n = 1'b0; mem_en_n = 1'b1; supply_fail = 1'b0;
        batt_low_a = ba; batt_low_b = bb;
        repeat (3) @(negedge clk);
        #1 chk1("R7 reset pf", pwr_fail_n, 1'b0);
        chk16("R7 reset selects", ram_sel_n, '1);
        rst_n = 1'b1;
        repeat (REC - 1) @(negedge clk);
        #1 chk1("R7 recovery still running", pwr_fail_n, 1'b0);
        @(negedge clk);
        #1 chk1("R7 recovery ended", pwr_fail_n, 1'b1);
    endtask

    task automatic t_decode_all;
        power_up(1'b0, 1'b0);
        for (int a = 0; a < NB; a++) access(a, 1'b0, "R2 decode");
    endtask

    task automatic t_addr_move;
        @(negedge clk);
        bank_addr = 4'd6; mem_en_n = 1'b0;
        #1 chk16("R3 start", ram_sel_n, sel_of(6));
        @(negedge clk);
        bank_addr = 4'd11;
        #1 chk16("R3 moved", ram_sel_n, sel_of(11));
        @(negedge clk);
        bank_addr = 4'd0;
        #1 chk16("R3 moved again", ram_sel_n, sel_of(0));
        mem_en_n = 1'b1;
        #1 chk16("R1 enable high", ram_sel_n, '1);
    endtask

    task automatic t_fail_idle;
        @(negedge clk);
        supply_fail = 1'b1;
        repeat (4) @(negedge clk);
        #1 chk1("R4 pf low", pwr_fail_n, 1'b0);
        mem_en_n = 1'b0; bank_addr = 4'd7;
        #1 chk16("R4 access blocked", ram_sel_n, '1);
        @(negedge clk);
        mem_en_n = 1'b1;
        supply_fail = 1'b0;
        for (int i = 1; i <= REC + 3; i++) begin
            @(negedge clk);
            if (i == 10) begin
                mem_en_n = 1'b0;
                #1 chk16("R6 blocked in recovery", ram_sel_n, '1);
                mem_en_n = 1'b1;
            end
            if (i == REC + 2) begin
                #1 chk1("R6 still low", pwr_fail_n, 1'b0);
            end
            if (i == REC + 3) begin
                #1 chk1("R6 released", pwr_fail_n, 1'b1);
            end
        end
        access(5, 1'b0, "R6 decode resumes");
    endtask

    task automatic t_hold;
        @(negedge clk);
        bank_addr = 4'd3; mem_en_n = 1'b0; supply_fail = 1'b1;
        repeat (4) @(negedge clk);
        #1 chk1("R5 pf low during hold", pwr_fail_n, 1'b0);
        chk16("R5 access kept", ram_sel_n, sel_of(3));
        bank_addr = 4'd9;
        #1 chk16("R5 address ignored", ram_sel_n, sel_of(3));
        @(negedge clk);
        mem_en_n = 1'b1;
        #1 chk16("R5 released on enable high", ram_sel_n, '1);
        repeat (2) @(negedge clk);
        mem_en_n = 1'b0;
        #1 chk16("R4 blocked after hold", ram_sel_n, '1);
        mem_en_n = 1'b1;
        supply_fail = 1'b0;
        repeat (REC + 4) @(negedge clk);
        #1 chk1("R6 back after hold", pwr_fail_n, 1'b1);
    endtask

    task automatic t_batt_both;
        power_up(1'b1, 1'b1);
        access(2, 1'b0, "R9 first access");
        access(4, 1'b1, "R8 second access");
        access(4, 1'b0, "R9 third access");
        access(13, 1'b0, "R9 fourth access");
    endtask

    task automatic t_batt_single;
        power_up(1'b1, 1'b0);
        access(1, 1'b0, "R10 a low first");
        access(1, 1'b0, "R10 a low second");
        power_up(1'b0, 1'b1);
        access(8, 1'b0, "R10 b low first");
        access(8, 1'b0, "R10 b low second");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_decode_all();
        t_addr_move();
        t_fail_idle();
        t_hold();
        t_batt_both();
        t_batt_single();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule